// File: doc/BRIEF.md
# Shadowed-Configuration Phase-Accumulator PWM

This block drives one pulse-width-modulated output from a single 32-bit configuration word written over a plain write strobe and read back combinationally. The word carries an output enable, an update request, a frequency increment and an inverted 8-bit duty field. The output frequency comes from a phase accumulator of `BASE_BITS` bits. The active increment is added to it on every clock while the output is enabled. One output cycle lasts from one accumulator wrap to the next.

Software writes new increment and duty values together with the update request. These values wait in the register and reach the generator only at the next output cycle start. At that moment the hardware clears the update request. Software polls the request bit and must not write again until it reads zero. Any write that arrives while the request is still set is discarded as a whole, so the values waiting to commit cannot be corrupted.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After reset the configuration read-back is all zeros and `pwm_out` is low.
- R2: Bit 31 of the word is the enable and bit 30 is the update request. The increment occupies bits [8 +: BASE_BITS] and the inverted duty field occupies bits [7:0]. `cfg_rdata` returns these fields as last accepted, with every other bit zero.
- R3: Staged values take effect at the next output cycle start, and the update bit clears on that same clock edge. A cycle start occurs on the first clock after enable is seen set, and on every accumulator wrap after that.
- R4: A write taken while the update bit reads 1 changes no field. The enable, the increment, the duty field and the values waiting to commit all stay as they were.
- R5: With an active increment `inc` that divides 2^BASE_BITS, the output period is 2^BASE_BITS / inc clocks.
- R6: `pwm_out` is high while the top 8 accumulator bits are below the threshold 255 − duty field. A duty field of 0 (threshold 255) holds the output high for the whole period.
- R7: While enable reads 0, `pwm_out` is low, starting on the clock after the clearing write, and the accumulator is held at zero.
- R8: An active increment of 0 produces no cycle start after the first one, so an update requested in that state stays pending.
- R9: The update bit rises only through an accepted write and falls only at a cycle start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Current configuration word |
| pwm_out | output | 1 | PWM output |

## Verification
The properties assume that software follows the polling rule. Each write is a single-cycle strobe, and a new configuration is written only after the update bit has been seen clear. A write during a pending update is still legal, and it is checked to be discarded. The stimulus always waits for the bit to clear before it writes again, except where it deliberately issues the write that should be dropped. Period and duty measurements use only increments that divide 2^BASE_BITS, so every output cycle has the same length.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int EN_BIT  = 31;
  localparam int UPD_BIT = 30;
  localparam int INC_LSB = 8;
  localparam int DUTY_W  = 8;

  // The duty field is stored inverted: the on-time threshold is its complement from 255.
  function automatic logic [DUTY_W-1:0] duty_to_thr(input logic [DUTY_W-1:0] fld);
    return {DUTY_W{1'b1}} - fld;
  endfunction
endpackage

// File: rtl/pwm_cfg_reg.sv
module pwm_cfg_reg
  import pwm_shadow_pkg::*;
#(
  parameter int BASE_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [31:0]          wdata_i,
  input  logic                 commit_i,
  output logic                 en_o,
  output logic                 upd_o,
  output logic [BASE_BITS-1:0] stg_inc_o,
  output logic [DUTY_W-1:0]    stg_duty_o,
  output logic [31:0]          rdata_o
);
  logic                 en_q, en_d;
  logic                 upd_q, upd_d;
  logic [BASE_BITS-1:0] inc_q, inc_d;
  logic [DUTY_W-1:0]    duty_q, duty_d;
  logic                 wr_take;

  // A write is accepted only when no update is pending.
  assign wr_take = wr_i & ~upd_q;

  always_comb begin
    en_d   = en_q;
    upd_d  = upd_q;
    inc_d  = inc_q;
    duty_d = duty_q;
    if (wr_take) begin
      en_d   = wdata_i[EN_BIT];
      upd_d  = wdata_i[UPD_BIT];
      inc_d  = wdata_i[INC_LSB +: BASE_BITS];
      duty_d = wdata_i[DUTY_W-1:0];
    end else if (commit_i) begin
      upd_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      upd_q  <= 1'b0;
      inc_q  <= '0;
      duty_q <= '0;
    end else begin
      en_q   <= en_d;
      upd_q  <= upd_d;
      inc_q  <= inc_d;
      duty_q <= duty_d;
    end
  end

  always_comb begin
    rdata_o                         = '0;
    rdata_o[EN_BIT]                 = en_q;
    rdata_o[UPD_BIT]                = upd_q;
    rdata_o[INC_LSB +: BASE_BITS]   = inc_q;
    rdata_o[DUTY_W-1:0]             = duty_q;
  end

  assign en_o       = en_q;
  assign upd_o      = upd_q;
  assign stg_inc_o  = inc_q;
  assign stg_duty_o = duty_q;
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc #(
  parameter int BASE_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic [BASE_BITS-1:0] inc_i,
  output logic [BASE_BITS-1:0] acc_o,
  output logic                 en_d_o,
  output logic                 start_o
);
  logic [BASE_BITS-1:0] acc_q, acc_d;
  logic                 en_d_q;
  logic [BASE_BITS:0]   sum;
  logic                 wrap;

  assign sum     = {1'b0, acc_q} + {1'b0, inc_i};
  assign wrap    = sum[BASE_BITS];
  assign start_o = en_i & (~en_d_q | wrap);

  always_comb begin
    if (en_i) acc_d = sum[BASE_BITS-1:0];
    else      acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      en_d_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      en_d_q <= en_i;
    end
  end

  assign acc_o  = acc_q;
  assign en_d_o = en_d_q;
endmodule

// File: rtl/pwm_active_set.sv
module pwm_active_set
  import pwm_shadow_pkg::*;
#(
  parameter int BASE_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 upd_i,
  input  logic [BASE_BITS-1:0] stg_inc_i,
  input  logic [DUTY_W-1:0]    stg_duty_i,
  output logic                 commit_o,
  output logic [BASE_BITS-1:0] act_inc_o,
  output logic [DUTY_W-1:0]    act_thr_o
);
  logic [BASE_BITS-1:0] inc_q, inc_d;
  logic [DUTY_W-1:0]    thr_q, thr_d;

  assign commit_o = start_i & upd_i;

  always_comb begin
    inc_d = inc_q;
    thr_d = thr_q;
    if (commit_o) begin
      inc_d = stg_inc_i;
      thr_d = duty_to_thr(stg_duty_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= '0;
      thr_q <= '0;
    end else begin
      inc_q <= inc_d;
      thr_q <= thr_d;
    end
  end

  assign act_inc_o = inc_q;
  assign act_thr_o = thr_q;
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp
  import pwm_shadow_pkg::*;
#(
  parameter int BASE_BITS = 10
) (
  input  logic                 en_i,
  input  logic [BASE_BITS-1:0] acc_i,
  input  logic [DUTY_W-1:0]    thr_i,
  output logic                 pwm_o
);
  logic [DUTY_W-1:0] phase_top;

  generate
    if (BASE_BITS >= DUTY_W) begin : g_wide
      assign phase_top = acc_i[BASE_BITS-1 -: DUTY_W];
    end else begin : g_narrow
      assign phase_top = {acc_i, {(DUTY_W-BASE_BITS){1'b0}}};
    end
  endgenerate

  assign pwm_o = en_i & ((thr_i == {DUTY_W{1'b1}}) | (phase_top < thr_i));
endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
  import pwm_shadow_pkg::*;
#(
  parameter int BASE_BITS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        pwm_out
);
  logic [1:0]           rst_pipe;
  logic                 rst_sync_n;
  logic                 en, upd, commit, cyc_start, en_d;
  logic [BASE_BITS-1:0] stg_inc, act_inc, acc;
  logic [DUTY_W-1:0]    stg_duty, act_thr;

  // Reset asserts asynchronously and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pwm_cfg_reg #(.BASE_BITS(BASE_BITS)) u_reg (
    .clk(clk), .rst_n(rst_sync_n), .wr_i(cfg_wr), .wdata_i(cfg_wdata),
    .commit_i(commit), .en_o(en), .upd_o(upd), .stg_inc_o(stg_inc),
    .stg_duty_o(stg_duty), .rdata_o(cfg_rdata)
  );

  pwm_phase_acc #(.BASE_BITS(BASE_BITS)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .en_i(en), .inc_i(act_inc),
    .acc_o(acc), .en_d_o(en_d), .start_o(cyc_start)
  );

  pwm_active_set #(.BASE_BITS(BASE_BITS)) u_act (
    .clk(clk), .rst_n(rst_sync_n), .start_i(cyc_start), .upd_i(upd),
    .stg_inc_i(stg_inc), .stg_duty_i(stg_duty), .commit_o(commit),
    .act_inc_o(act_inc), .act_thr_o(act_thr)
  );

  pwm_duty_cmp #(.BASE_BITS(BASE_BITS)) u_cmp (
    .en_i(en), .acc_i(acc), .thr_i(act_thr), .pwm_o(pwm_out)
  );
endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk #(
  parameter int BASE_BITS = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_wr,
  input logic [31:0]          cfg_rdata,
  input logic                 pwm_out,
  input logic                 cyc_start,
  input logic                 en_d,
  input logic [BASE_BITS-1:0] act_inc
);
  AST_OUT_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[31] |-> !pwm_out); // R7

  AST_PENDING_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_rdata[30]) |=> (cfg_rdata[31] == $past(cfg_rdata[31]) &&
                                   cfg_rdata[29:0] == $past(cfg_rdata[29:0]))); // R4

  AST_UPD_CLEARS_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_rdata[30]) |-> $past(cyc_start)); // R3

  AST_UPD_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[30]) |-> $past(cfg_wr)); // R9

  AST_ZERO_INC_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (en_d && act_inc == '0) |-> !cyc_start); // R8
endmodule

bind pwm_shadow_gen pwm_shadow_chk #(.BASE_BITS(BASE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata),
  .pwm_out(pwm_out), .cyc_start(cyc_start), .en_d(en_d), .act_inc(act_inc)
);

// File: tb/tb_pwm_shadow_gen.sv
module tb_pwm_shadow_gen;
  localparam int BASE_BITS = 10;

  logic        clk, rst_n, cfg_wr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        pwm_out;
  int          n_chk = 0, n_bad = 0;

  // Table entries: increment, duty field, expected period, expected high clocks.
  localparam int VEC [4][4] = '{'{64, 127, 16, 8}, '{128, 191, 8, 2},
                                '{32, 63, 32, 24}, '{256, 223, 4, 1}};

  pwm_shadow_gen #(.BASE_BITS(BASE_BITS)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pwm_out(pwm_out)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  function automatic logic [31:0] word(input bit en, input bit upd, input int inc, input int duty);
    logic [31:0] w;
    w = '0;
    w[31] = en;
    w[30] = upd;
    w[8 +: BASE_BITS] = inc[BASE_BITS-1:0];
    w[7:0] = duty[7:0];
    return w;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_clear(output int cnt);
    cnt = 0;
    while (cfg_rdata[30] && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic measure(output int per, output int hi);
    logic prev, cur;
    prev = pwm_out;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!prev && pwm_out) break;
      prev = pwm_out;
    end
    per = 0;
    hi = 0;
    for (int i = 0; i < 5000; i++) begin
      cur = pwm_out;
      per++;
      if (cur) hi++;
      @(negedge clk);
      if (!cur && pwm_out) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_wr = 1'b0;
    cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt, per, hi, lowcnt, highcnt;
    logic [31:0] wa, wb;
    do_reset();
    chk("R1 rdata after reset", cfg_rdata, 0);
    chk("R1 pwm after reset", pwm_out, 0);

    // First enable: commit happens on the first clock after enable is set.
    wr(word(1, 1, 1, 127));
    chk("R3 update bit set before start", cfg_rdata[30], 1);
    @(negedge clk);
    chk("R3 R2 update cleared at enable start", cfg_rdata, word(1, 0, 1, 127));

    // Pending update with a long period, then a write that must be dropped.
    wa = word(1, 1, 64, 127);
    wb = word(1, 1, 128, 191);
    wr(wa);
    wr(wb);
    chk("R4 dropped write leaves register", cfg_rdata, wa);
    wait_clear(cnt);
    chk("R3 commit waits for wrap", (cnt > 100 && cnt < 1100) ? 1 : 0, 1);
    chk("R2 fields after commit", cfg_rdata, word(1, 0, 64, 127));
    repeat (40) @(negedge clk);
    measure(per, hi);
    chk("R4 R5 period uses first write", per, 16);
    chk("R4 R6 high time uses first write", hi, 8);

    // Table of increment and duty settings.
    for (int v = 0; v < 4; v++) begin
      wr(word(1, 1, VEC[v][0], VEC[v][1]));
      wait_clear(cnt);
      repeat (70) @(negedge clk);
      measure(per, hi);
      chk("R5 period", per, VEC[v][2]);
      chk("R6 high clocks", hi, VEC[v][3]);
    end

    // Disable: output low at once and stays low.
    wr(word(0, 0, 64, 127));
    highcnt = 0;
    for (int i = 0; i < 30; i++) begin
      if (pwm_out) highcnt++;
      @(negedge clk);
    end
    chk("R7 output low while disabled", highcnt, 0);
    chk("R7 enable reads clear", cfg_rdata[31], 0);

    // Duty field 0 holds the output high.
    wr(word(1, 1, 64, 0));
    repeat (2) @(negedge clk);
    lowcnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (!pwm_out) lowcnt++;
      @(negedge clk);
    end
    chk("R6 duty zero always high", lowcnt, 0);

    // Zero increment: after commit no further starts, so a new update stays pending.
    wr(word(1, 1, 0, 127));
    wait_clear(cnt);
    chk("R8 zero increment committed", cfg_rdata, word(1, 0, 0, 127));
    wr(word(1, 1, 64, 127));
    repeat (200) @(negedge clk);
    chk("R8 R9 update stays pending", cfg_rdata[30], 1);

    do_reset();
    chk("R1 rdata after second reset", cfg_rdata, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule